// File: doc/BRIEF.md
# Tag-Only Cache with Stall Accounting

This block models the timing cost of a set-associative cache without holding any data. It accepts one memory transaction at a time. Each transaction carries a line address, a kind (read, write, instruction fetch or prefetch) and an uncacheable flag. The block looks the line up in its tag store and decides between a hit and a miss. On a miss it picks a victim way. It then returns one total stall value, which is the sum of programmable access, miss and snoop penalties together with the costs that the next level supplies for a write-back and for a line fill. A transaction is never retried. Valid, dirty and recency state is kept for every line.

Software loads the penalties through a small configuration write port. That port also selects how write misses are handled: write-allocate or write-through. The cost of a next-level write-back, the cost of a line fill, and the snoop outcome for the current miss are all driven as inputs alongside the request.

Top module: `stall_cache`

## Requirements
- R1: `req_ready` is high whenever `done` is low. A request that is accepted (`req_valid && req_ready` at a rising edge) makes `done` high for exactly the one following cycle. The `stall`, `was_hit` and `copy_back` outputs are valid in that cycle.
- R2: A request with `req_uncached` = 1 reports stall 0, `was_hit` 0 and `copy_back` 0. It leaves tags, dirty bits and recency untouched.
- R3: A read (kind 0) or instruction fetch (kind 2) that hits reports exactly the read access penalty, and `was_hit` = 1.
- R4: A miss fills the lowest-numbered invalid way of the set. If every way is valid, it fills the least recently used way. Any hit or fill makes the touched way the most recently used.
- R5: When the chosen victim is valid and dirty, `copy_back` = 1 and `nl_wr_pen` is added to the stall. A clean victim adds nothing and gives `copy_back` = 0.
- R6: A read or instruction-fetch miss reports the sum of the following: read access penalty, copy-back cost, line fill (read access penalty + `nl_rd_pen`), read miss penalty and snoop cost. The line is installed clean.
- R7: The snoop cost is added on every cacheable miss. It is the snoop penalty, plus `snoop_flush_pen` when `snoop_dirty` = 1.
- R8: A write (kind 1) that hits reports the write access penalty. Under write-allocate the line becomes dirty. Under write-through it stays clean.
- R9: Under write-allocate, a write miss reports the write access penalty plus copy-back, line fill, read miss penalty and snoop cost. The line is installed dirty.
- R10: Under write-through, a write miss reports the write access penalty plus the write miss penalty plus the snoop cost. It allocates nothing and touches no recency state.
- R11: A prefetch (kind 3) updates tags and recency exactly like a read, but reports stall 0.
- R12: The configuration port is selected by `cfg_sel`: 0 read access, 1 write access, 2 read miss, 3 write miss, 4 snoop, 5 policy (`cfg_data[0]`, where 1 means write-allocate). After reset every penalty is zero and the policy is write-allocate. Zero penalties are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_data | input | PEN_W | Configuration write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_line | input | LADDR_W | Line address; the low bits select the set |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch, 3 prefetch |
| req_uncached | input | 1 | Bypass the cache |
| nl_wr_pen | input | PEN_W | Next-level cost of a write-back |
| nl_rd_pen | input | PEN_W | Next-level cost returned for a line fill |
| snoop_dirty | input | 1 | Snooped cache must flush a modified line |
| snoop_flush_pen | input | PEN_W | Cost of that flush |
| done | output | 1 | Result valid, one-cycle pulse |
| stall | output | STALL_W | Total stall cycles of the transaction |
| was_hit | output | 1 | Transaction hit in the cache |
| copy_back | output | 1 | A dirty victim was written back |

## Verification
Read and instruction-fetch streams are run over cold sets, warm sets and full sets. Comparing their costs separates hit pricing from fill pricing, and shows whether recency selects the correct victim. Write streams are run under both policies. They separate allocation from forwarding, and a later eviction reveals whether the dirty state was set, because `copy_back` either appears or does not. Prefetch and uncacheable requests are each followed by an ordinary access to the same line. Whether that access hits or misses shows whether the earlier request changed the tag state, even though the earlier request itself reported no cost.

// File: rtl/stall_cache_pkg.sv
package stall_cache_pkg;

  typedef enum logic [1:0] {
    K_READ     = 2'd0,
    K_WRITE    = 2'd1,
    K_IFETCH   = 2'd2,
    K_PREFETCH = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    SEL_RD_ACC  = 3'd0,
    SEL_WR_ACC  = 3'd1,
    SEL_RD_MISS = 3'd2,
    SEL_WR_MISS = 3'd3,
    SEL_SNOOP   = 3'd4,
    SEL_POLICY  = 3'd5
  } cfg_sel_e;

  // How a cacheable or uncacheable request is resolved
  typedef enum logic [1:0] {
    PATH_HIT     = 2'd0,
    PATH_FILL    = 2'd1,
    PATH_THROUGH = 2'd2,
    PATH_BYPASS  = 2'd3
  } path_e;

endpackage

// File: rtl/stall_cache_cfg.sv
module stall_cache_cfg
  import stall_cache_pkg::*;
#(
  parameter int PEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [PEN_W-1:0] cfg_data,
  output logic [PEN_W-1:0] rd_acc,
  output logic [PEN_W-1:0] wr_acc,
  output logic [PEN_W-1:0] rd_miss,
  output logic [PEN_W-1:0] wr_miss,
  output logic [PEN_W-1:0] snoop,
  output logic             wr_alloc
);

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_acc   <= '0;
      wr_acc   <= '0;
      rd_miss  <= '0;
      wr_miss  <= '0;
      snoop    <= '0;
      wr_alloc <= 1'b1;
    end else if (cfg_we) begin
      case (sel)
        SEL_RD_ACC:  rd_acc   <= cfg_data;
        SEL_WR_ACC:  wr_acc   <= cfg_data;
        SEL_RD_MISS: rd_miss  <= cfg_data;
        SEL_WR_MISS: wr_miss  <= cfg_data;
        SEL_SNOOP:   snoop    <= cfg_data;
        SEL_POLICY:  wr_alloc <= cfg_data[0];
        default: ;
      endcase
    end
  end

  // R12
  cfg_policy_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> wr_alloc);

endmodule

// File: rtl/stall_cache_tags.sv
module stall_cache_tags #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int IDX_W = 2,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_oh,
  output logic [WAYS-1:0]  victim_oh,
  output logic             victim_dirty,
  input  logic             upd_touch,
  input  logic             upd_fill,
  input  logic             upd_fill_dirty,
  input  logic             upd_mark_dirty,
  input  logic [WAYS-1:0]  upd_way_oh
);

  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [AGE_W-1:0] age_q   [SETS][WAYS];

  logic [AGE_W-1:0] touched_age;
  logic             any_invalid;

  // Tag compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_oh[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  // Victim: lowest invalid way, else the way holding the oldest rank
  always_comb begin
    victim_oh   = '0;
    any_invalid = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!any_invalid && !valid_q[lk_idx][w]) begin
        victim_oh[w] = 1'b1;
        any_invalid  = 1'b1;
      end
    end
    if (!any_invalid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[lk_idx][w] == AGE_OLDEST) victim_oh[w] = 1'b1;
      end
    end
  end

  assign victim_dirty = |(victim_oh & valid_q[lk_idx] & dirty_q[lk_idx]);

  always_comb begin
    touched_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (upd_way_oh[w]) touched_age = touched_age | age_q[lk_idx][w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else begin
      if (upd_touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (upd_way_oh[w])
            age_q[lk_idx][w] <= '0;
          else if (age_q[lk_idx][w] < touched_age)
            age_q[lk_idx][w] <= age_q[lk_idx][w] + 1'b1;
        end
      end
      if (upd_fill) begin
        for (int w = 0; w < WAYS; w++) begin
          if (upd_way_oh[w]) begin
            valid_q[lk_idx][w] <= 1'b1;
            tag_q[lk_idx][w]   <= lk_tag;
            dirty_q[lk_idx][w] <= upd_fill_dirty;
          end
        end
      end
      if (upd_mark_dirty) begin
        for (int w = 0; w < WAYS; w++) begin
          if (upd_way_oh[w]) dirty_q[lk_idx][w] <= 1'b1;
        end
      end
    end
  end

  // R4
  victim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(victim_oh));

  // R4
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_oh));

  // R4
  touch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_touch |-> $onehot(upd_way_oh));

endmodule

// File: rtl/stall_cache_acct.sv
module stall_cache_acct
  import stall_cache_pkg::*;
#(
  parameter int PEN_W   = 8,
  parameter int STALL_W = 12
) (
  input  kind_e              kind,
  input  logic               uncached,
  input  logic               hit,
  input  logic               victim_dirty,
  input  logic               wr_alloc,
  input  logic [PEN_W-1:0]   rd_acc,
  input  logic [PEN_W-1:0]   wr_acc,
  input  logic [PEN_W-1:0]   rd_miss,
  input  logic [PEN_W-1:0]   wr_miss,
  input  logic [PEN_W-1:0]   snoop,
  input  logic [PEN_W-1:0]   nl_wr_pen,
  input  logic [PEN_W-1:0]   nl_rd_pen,
  input  logic               snoop_dirty,
  input  logic [PEN_W-1:0]   snoop_flush_pen,
  output path_e              path,
  output logic               copy_back,
  output logic [STALL_W-1:0] stall_val
);

  function automatic logic [STALL_W-1:0] widen(input logic [PEN_W-1:0] p);
    return STALL_W'(p);
  endfunction

  function automatic logic [STALL_W-1:0] fill_cost(input logic [PEN_W-1:0] acc,
                                                   input logic [PEN_W-1:0] ret);
    return widen(acc) + widen(ret);
  endfunction

  function automatic logic [STALL_W-1:0] snoop_cost(input logic [PEN_W-1:0] base,
                                                    input logic flush,
                                                    input logic [PEN_W-1:0] fpen);
    return widen(base) + (flush ? widen(fpen) : '0);
  endfunction

  function automatic logic [STALL_W-1:0] evict_cost(input logic dirty,
                                                    input logic [PEN_W-1:0] wpen);
    return dirty ? widen(wpen) : '0;
  endfunction

  logic               is_write;
  logic [STALL_W-1:0] access_part;
  logic [STALL_W-1:0] raw_total;

  assign is_write    = (kind == K_WRITE);
  assign access_part = is_write ? widen(wr_acc) : widen(rd_acc);

  always_comb begin
    if (uncached)
      path = PATH_BYPASS;
    else if (hit)
      path = PATH_HIT;
    else if (is_write && !wr_alloc)
      path = PATH_THROUGH;
    else
      path = PATH_FILL;
  end

  always_comb begin
    case (path)
      PATH_HIT:     raw_total = access_part;
      PATH_THROUGH: raw_total = access_part + widen(wr_miss)
                              + snoop_cost(snoop, snoop_dirty, snoop_flush_pen);
      PATH_FILL:    raw_total = access_part
                              + evict_cost(victim_dirty, nl_wr_pen)
                              + fill_cost(rd_acc, nl_rd_pen)
                              + widen(rd_miss)
                              + snoop_cost(snoop, snoop_dirty, snoop_flush_pen);
      default:      raw_total = '0;
    endcase
  end

  assign copy_back = (path == PATH_FILL) && victim_dirty;
  assign stall_val = (kind == K_PREFETCH) ? '0 : raw_total;

endmodule

// File: rtl/stall_cache.sv
module stall_cache
  import stall_cache_pkg::*;
#(
  parameter int LADDR_W = 12,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int PEN_W   = 8,
  parameter int STALL_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [PEN_W-1:0]   cfg_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_line,
  input  logic [1:0]         req_kind,
  input  logic               req_uncached,
  input  logic [PEN_W-1:0]   nl_wr_pen,
  input  logic [PEN_W-1:0]   nl_rd_pen,
  input  logic               snoop_dirty,
  input  logic [PEN_W-1:0]   snoop_flush_pen,
  output logic               done,
  output logic [STALL_W-1:0] stall,
  output logic               was_hit,
  output logic               copy_back
);

  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = LADDR_W - IDX_W;

  kind_e              req_k;
  logic               accept;
  logic [IDX_W-1:0]   set_idx;
  logic [TAG_W-1:0]   line_tag;
  logic [PEN_W-1:0]   rd_acc, wr_acc, rd_miss, wr_miss, snoop;
  logic               wr_alloc;
  logic [WAYS-1:0]    hit_oh, victim_oh;
  logic               hit_any, victim_dirty;
  path_e              path;
  logic               cb_now;
  logic [STALL_W-1:0] stall_now;
  logic               upd_touch, upd_fill, upd_mark_dirty;
  logic [WAYS-1:0]    upd_way_oh;

  assign req_k    = kind_e'(req_kind);
  assign req_ready = !done;
  assign accept   = req_valid && req_ready;
  assign set_idx  = req_line[IDX_W-1:0];
  assign line_tag = req_line[LADDR_W-1:IDX_W];
  assign hit_any  = |hit_oh;

  stall_cache_cfg #(.PEN_W(PEN_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .rd_acc   (rd_acc),
    .wr_acc   (wr_acc),
    .rd_miss  (rd_miss),
    .wr_miss  (wr_miss),
    .snoop    (snoop),
    .wr_alloc (wr_alloc)
  );

  stall_cache_tags #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_idx         (set_idx),
    .lk_tag         (line_tag),
    .hit_oh         (hit_oh),
    .victim_oh      (victim_oh),
    .victim_dirty   (victim_dirty),
    .upd_touch      (upd_touch),
    .upd_fill       (upd_fill),
    .upd_fill_dirty (req_k == K_WRITE),
    .upd_mark_dirty (upd_mark_dirty),
    .upd_way_oh     (upd_way_oh)
  );

  stall_cache_acct #(.PEN_W(PEN_W), .STALL_W(STALL_W)) u_acct (
    .kind            (req_k),
    .uncached        (req_uncached),
    .hit             (hit_any),
    .victim_dirty    (victim_dirty),
    .wr_alloc        (wr_alloc),
    .rd_acc          (rd_acc),
    .wr_acc          (wr_acc),
    .rd_miss         (rd_miss),
    .wr_miss         (wr_miss),
    .snoop           (snoop),
    .nl_wr_pen       (nl_wr_pen),
    .nl_rd_pen       (nl_rd_pen),
    .snoop_dirty     (snoop_dirty),
    .snoop_flush_pen (snoop_flush_pen),
    .path            (path),
    .copy_back       (cb_now),
    .stall_val       (stall_now)
  );

  // State changes only for requests that reach the tag store
  assign upd_way_oh     = hit_any ? hit_oh : victim_oh;
  assign upd_touch      = accept && (path == PATH_HIT || path == PATH_FILL);
  assign upd_fill       = accept && (path == PATH_FILL);
  assign upd_mark_dirty = accept && (path == PATH_HIT) && (req_k == K_WRITE) && wr_alloc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      stall     <= '0;
      was_hit   <= 1'b0;
      copy_back <= 1'b0;
    end else begin
      done <= accept;
      if (accept) begin
        stall     <= stall_now;
        was_hit   <= (path == PATH_HIT);
        copy_back <= cb_now;
      end
    end
  end

  // R1
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  bypass_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_uncached) |=> (stall == '0 && !was_hit && !copy_back));

  // R2
  bypass_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_uncached) |-> !(upd_touch || upd_fill || upd_mark_dirty));

  // R3
  read_hit_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_uncached && hit_any && (req_k == K_READ || req_k == K_IFETCH))
      |=> (stall == STALL_W'($past(rd_acc)) && was_hit));

  // R11
  prefetch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_k == K_PREFETCH) |=> (stall == '0));

  // R5
  copy_back_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_back |-> !was_hit);

endmodule

// File: tb/stall_cache_tb.sv
module stall_cache_tb;

  localparam int RP = 3, WP = 2, RMP = 10, WMP = 7, SP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_line = '0;
  logic [1:0]  req_kind = '0;
  logic        req_uncached = 1'b0;
  logic [7:0]  nl_wr_pen = '0;
  logic [7:0]  nl_rd_pen = '0;
  logic        snoop_dirty = 1'b0;
  logic [7:0]  snoop_flush_pen = '0;
  logic        done;
  logic [11:0] stall;
  logic        was_hit;
  logic        copy_back;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  stall_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .req_kind(req_kind), .req_uncached(req_uncached), .nl_wr_pen(nl_wr_pen),
    .nl_rd_pen(nl_rd_pen), .snoop_dirty(snoop_dirty), .snoop_flush_pen(snoop_flush_pen),
    .done(done), .stall(stall), .was_hit(was_hit), .copy_back(copy_back)
  );

  function automatic int mk(input int tag, input int set);
    return tag * 4 + set;
  endfunction

  // Expected miss-with-fill cost, written from the requirement text
  function automatic int fill_exp(input int acc, input int wb, input int ret,
                                  input int flush);
    return acc + wb + (RP + ret) + RMP + SP + flush;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input int line, input int kind, input bit unc,
                        input int nlw, input int nlr, input bit sd, input int sf,
                        output int st, output int h, output int cb);
    @(negedge clk);
    req_line = 12'(line); req_kind = 2'(kind); req_uncached = unc;
    nl_wr_pen = 8'(nlw); nl_rd_pen = 8'(nlr); snoop_dirty = sd; snoop_flush_pen = 8'(sf);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 done pulse", int'(done), 1);
    st = int'(stall); h = int'(was_hit); cb = int'(copy_back);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 done after reset", int'(done), 0);
    check("R12 stall after reset", int'(stall), 0);
  endtask

  task automatic t_zero_penalties();
    int st, h, cb;
    // R12: all penalties zero, only the fill return counts
    do_req(mk(1, 3), 0, 0, 9, 5, 0, 0, st, h, cb);
    check("R12 zero penalties miss", st, 5);
    check("R12 zero penalties hit flag", h, 0);
  endtask

  task automatic t_read_path();
    int st, h, cb;
    do_req(mk(1, 0), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R6 read miss total", st, fill_exp(RP, 0, 6, 0));
    check("R6 read miss hit flag", h, 0);
    @(negedge clk);
    check("R1 done drops", int'(done), 0);
    check("R1 ready returns", int'(req_ready), 1);
    do_req(mk(1, 0), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R3 read hit cost", st, RP);
    check("R3 read hit flag", h, 1);
    do_req(mk(1, 0), 2, 0, 9, 6, 0, 0, st, h, cb);
    check("R3 ifetch hit cost", st, RP);
  endtask

  task automatic t_lru();
    int st, h, cb;
    do_req(mk(2, 1), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 cold miss A", h, 0);
    do_req(mk(3, 1), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 second way B", h, 0);
    do_req(mk(2, 1), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 A still present", h, 1);
    do_req(mk(4, 1), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 C fills over LRU", st, fill_exp(RP, 0, 6, 0));
    do_req(mk(2, 1), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 A kept as MRU", h, 1);
    do_req(mk(3, 1), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 B was evicted", h, 0);
  endtask

  task automatic t_write_allocate();
    int st, h, cb;
    do_req(mk(5, 2), 1, 0, 9, 6, 0, 0, st, h, cb);
    check("R9 write-allocate miss", st, fill_exp(WP, 0, 6, 0));
    do_req(mk(5, 2), 1, 0, 9, 6, 0, 0, st, h, cb);
    check("R8 write hit cost", st, WP);
    check("R8 write hit flag", h, 1);
    do_req(mk(6, 2), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 E fills free way", h, 0);
    // D is LRU and dirty; snooped cache also flushes
    do_req(mk(7, 2), 0, 0, 9, 6, 1, 5, st, h, cb);
    check("R5 dirty victim total", st, fill_exp(RP, 9, 6, 5));
    check("R5 copy_back flag", cb, 1);
    check("R7 flush included", st - fill_exp(RP, 9, 6, 0), 5);
    do_req(mk(8, 2), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R5 clean victim total", st, fill_exp(RP, 0, 6, 0));
    check("R5 clean victim flag", cb, 0);
  endtask

  task automatic t_write_through();
    int st, h, cb;
    cfg_write(5, 0);
    do_req(mk(9, 3), 1, 0, 9, 6, 0, 0, st, h, cb);
    check("R10 write-through miss", st, WP + WMP + SP);
    do_req(mk(9, 3), 1, 0, 9, 6, 0, 0, st, h, cb);
    check("R10 no allocation", h, 0);
    do_req(mk(9, 3), 1, 0, 9, 6, 1, 3, st, h, cb);
    check("R7 snoop on write-through miss", st, WP + WMP + SP + 3);
    do_req(mk(1, 3), 1, 0, 9, 6, 0, 0, st, h, cb);
    check("R8 write-through hit cost", st, WP);
    do_req(mk(10, 3), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R4 X fills free way", h, 0);
    do_req(mk(11, 3), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R8 write-through hit left line clean", cb, 0);
    check("R8 clean eviction total", st, fill_exp(RP, 0, 6, 0));
    cfg_write(5, 1);
  endtask

  task automatic t_prefetch();
    int st, h, cb;
    do_req(mk(12, 0), 3, 0, 9, 6, 1, 5, st, h, cb);
    check("R11 prefetch reports zero", st, 0);
    do_req(mk(12, 0), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R11 prefetched line hits", h, 1);
    check("R11 prefetched line cost", st, RP);
  endtask

  task automatic t_uncached();
    int st, h, cb;
    do_req(mk(13, 0), 0, 1, 9, 6, 1, 5, st, h, cb);
    check("R2 uncached cost", st, 0);
    check("R2 uncached hit flag", h, 0);
    do_req(mk(1, 0), 1, 1, 9, 6, 0, 0, st, h, cb);
    check("R2 uncached write to resident line", st + h, 0);
    // tag 1 is LRU; it must still be clean and tag 13 must be absent
    do_req(mk(13, 0), 0, 0, 9, 6, 0, 0, st, h, cb);
    check("R2 uncached did not allocate", h, 0);
    check("R2 uncached did not dirty", cb, 0);
    check("R2 following miss total", st, fill_exp(RP, 0, 6, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_penalties();
    cfg_write(0, RP);
    cfg_write(1, WP);
    cfg_write(2, RMP);
    cfg_write(3, WMP);
    cfg_write(4, SP);
    t_read_path();
    t_lru();
    t_write_allocate();
    t_write_through();
    t_prefetch();
    t_uncached();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule